// File: doc/BRIEF.md
# Sensor SPI Frame Engine

This block is an SPI master that runs one register access against an inertial sensor using fixed 32-bit frames. A request gives a register address, a read/write flag and a 16-bit word. The engine builds a command frame from these and appends an inverted CRC-8 byte. It then shifts the frame out in SPI mode 0, with the clock idling low, data changing on the falling edge and data sampled on the rising edge.

The sensor answers each frame during the frame that follows it. For this reason every request uses two frames. The engine sends the command once, releases chip select for at least the minimum gap, and sends the same command again to collect the reply. It then checks the reply's CRC trailer and extracts the two return-status bits and the 16-bit data word. It reports the result as a one-cycle completion pulse, with a CRC-fault flag or a device-fault flag beside it where one applies.

The minimum chip-select gap is set from two parameters: the system clock frequency and the required gap in microseconds. The rest of the chip presents requests one at a time and waits for `busy` to fall before sending the next.

Top module: `sens_frame_eng`

## Requirements
- R1: Each frame is 32 bits, sent MSB first on `spi_mosi`. Bit 31 is 1 for a write and 0 for a read. Bits 30:26 hold the register address, bits 25:24 are 0, and bits 23:8 hold the write word (all zero for a read). `spi_sclk` is low whenever `spi_cs_n` is high, and `spi_mosi` never changes at a rising edge of `spi_sclk`.
- R2: Bits 7:0 of each frame are the bitwise inverse of a CRC-8 computed MSB first over bits 31:8, using polynomial 0x1D and a start value of 0xFF. Example: a read of address 6 sends 0x180000E5.
- R3: Every request produces exactly two identical frames. `spi_cs_n` goes high between them, and each frame has exactly 32 rising edges of `spi_sclk`.
- R4: Before every fall of `spi_cs_n`, `spi_cs_n` has been high for at least GAP_CLKS system clocks, where GAP_CLKS = (CLK_FREQ_HZ / 1,000,000) × GAP_US. This holds after reset, between the two frames of a request, and between consecutive requests.
- R5: The result is taken from the second frame only. The data word is bits 23:8 of that reply, received big-endian, and is presented on `rdata` sign-extended to OUT_W bits.
- R6: If bits 7:0 of the reply differ from the inverted CRC-8 of reply bits 31:8, `crc_err` pulses together with `done`. In that case `rdata` and `rstat` keep their previous values.
- R7: When the reply CRC is correct, `rstat` takes reply bits 25:24. `dev_err` pulses with `done` exactly when that value is 3. `crc_err` and `dev_err` are never high together.
- R8: `busy` rises in the cycle after a request is accepted and stays high until the reply has been checked. `done` is a one-cycle pulse that appears in the same cycle in which `busy` falls.
- R9: `req_valid` is ignored while `busy` is high. Neither the frames sent nor the number of `done` pulses change.
- R10: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `busy`, `done`, `crc_err` and `dev_err` are 0, and `rdata` and `rstat` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | 16 | Word to write (ignored for reads) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| crc_err | output | 1 | Reply CRC mismatch, valid with `done` |
| dev_err | output | 1 | Reply status equals 3, valid with `done` |
| rstat | output | 2 | Return status from the last good reply |
| rdata | output | OUT_W | Sign-extended data word from the last good reply |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_miso | input | 1 | Serial data from the sensor |

## Verification
The hardest case to reach is a reply whose content differs between the two frames of a single request. The engine must throw away the first frame's reply even when that reply is perfectly formed. To exercise this, the bench's sensor model returns a first-frame reply that carries a valid CRC, a fault status and a distinctive data word. It returns the expected reply only in the second frame, so any use of the wrong frame shows up as a wrong word or a spurious fault flag. Corrupted trailers and extra request strobes are fed in while the engine is busy, to reach the hold and ignore behaviour.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   localparam int FRAME_W = 32;
   localparam int PAY_W   = 24;
   localparam int WORD_W  = 16;
   localparam logic [7:0] CRC_POLY = 8'h1D;
   localparam logic [7:0] CRC_SEED = 8'hFF;
   localparam logic [1:0] RS_FAULT = 2'b11;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_RUN,
      ST_CHECK
   } sfe_state_t;
endpackage

// File: rtl/sfe_crc8.sv
module sfe_crc8
   import sfe_pkg::*;
#(
   parameter int         N_BITS = PAY_W,
   parameter logic [7:0] POLY   = CRC_POLY,
   parameter logic [7:0] SEED   = CRC_SEED
) (
   input  logic [N_BITS-1:0] data,
   output logic [7:0]        crc_inv
);
   // bit-serial CRC unrolled over the payload, MSB first
   always_comb begin
      logic [7:0] c;
      c = SEED;
      for (int i = N_BITS - 1; i >= 0; i--) begin
         if (c[7] ^ data[i]) c = {c[6:0], 1'b0} ^ POLY;
         else                c = {c[6:0], 1'b0};
      end
      crc_inv = ~c;
   end
endmodule

// File: rtl/sfe_gap_timer.sv
module sfe_gap_timer #(
   parameter int GAP_CLKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   output logic gap_ok
);
   localparam int CW = $clog2(GAP_CLKS + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (!cs_n)                   cnt <= '0;
      else if (cnt != CW'(GAP_CLKS))    cnt <= cnt + CW'(1);
   end

   assign gap_ok = (cnt == CW'(GAP_CLKS));
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter
   import sfe_pkg::*;
#(
   parameter int CLK_DIV = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] tx_frame,
   input  logic               miso,
   output logic               sclk,
   output logic               cs_n,
   output logic               mosi,
   output logic               fin,
   output logic [FRAME_W-1:0] rx_frame
);
   localparam int DIV_W = $clog2(CLK_DIV + 1);
   localparam int BIT_W = $clog2(FRAME_W);

   logic [DIV_W-1:0]   div_cnt;
   logic [BIT_W-1:0]   bit_cnt;
   logic [FRAME_W-1:0] tx_sh;
   logic               tick;

   assign tick = (div_cnt == DIV_W'(CLK_DIV - 1));
   assign mosi = tx_sh[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n     <= 1'b1;
         sclk     <= 1'b0;
         fin      <= 1'b0;
         div_cnt  <= '0;
         bit_cnt  <= '0;
         tx_sh    <= '0;
         rx_frame <= '0;
      end else begin
         fin <= 1'b0;
         if (cs_n) begin
            if (start) begin
               cs_n    <= 1'b0;
               tx_sh   <= tx_frame;
               bit_cnt <= '0;
               div_cnt <= '0;
            end
         end else if (tick) begin
            div_cnt <= '0;
            if (!sclk) begin
               sclk     <= 1'b1;
               rx_frame <= {rx_frame[FRAME_W-2:0], miso};
            end else begin
               sclk <= 1'b0;
               if (bit_cnt == BIT_W'(FRAME_W - 1)) begin
                  cs_n <= 1'b1;
                  fin  <= 1'b1;
               end else begin
                  bit_cnt <= bit_cnt + BIT_W'(1);
                  tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
               end
            end
         end else begin
            div_cnt <= div_cnt + DIV_W'(1);
         end
      end
   end
endmodule

// File: rtl/sens_frame_eng.sv
module sens_frame_eng
   import sfe_pkg::*;
#(
   parameter int CLK_FREQ_HZ = 100_000_000,
   parameter int GAP_US      = 10,
   parameter int CLK_DIV     = 4,
   parameter int ADDR_W      = 5,
   parameter int OUT_W       = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [15:0]       req_wdata,
   output logic              busy,
   output logic              done,
   output logic              crc_err,
   output logic              dev_err,
   output logic [1:0]        rstat,
   output logic [OUT_W-1:0]  rdata,
   output logic              spi_sclk,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   localparam int GAP_CLKS = (CLK_FREQ_HZ / 1_000_000) * GAP_US;

   // elaboration-time parameter checks
   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 5) begin : g_bad_addr
      $error("ADDR_W must be between 1 and 5");
   end
   if (OUT_W < WORD_W) begin : g_bad_out
      $error("OUT_W must be at least 16");
   end
   if (GAP_CLKS < 1) begin : g_bad_gap
      $error("gap must span at least one clock");
   end

   sfe_state_t         state;
   logic               second;
   logic [FRAME_W-1:0] cmd_frame;
   logic [PAY_W-1:0]   req_payload;
   logic [7:0]         tx_crc;
   logic [7:0]         rx_crc;
   logic [FRAME_W-1:0] rx_frame;
   logic               fin;
   logic               gap_ok;
   logic               start;
   logic               crc_ok;
   logic [OUT_W-1:0]   ext_word;

   assign req_payload = {req_write, 5'(req_addr), 2'b00,
                         (req_write ? req_wdata : 16'h0000)};

   sfe_crc8 u_tx_crc (.data(req_payload),                .crc_inv(tx_crc));
   sfe_crc8 u_rx_crc (.data(rx_frame[FRAME_W-1:8]),      .crc_inv(rx_crc));

   assign crc_ok = (rx_crc == rx_frame[7:0]);

   if (OUT_W == WORD_W) begin : g_ext_none
      assign ext_word = rx_frame[23:8];
   end else begin : g_ext_sign
      assign ext_word = {{(OUT_W - WORD_W){rx_frame[23]}}, rx_frame[23:8]};
   end

   sfe_gap_timer #(.GAP_CLKS(GAP_CLKS)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (spi_cs_n),
      .gap_ok (gap_ok)
   );

   assign start = (state == ST_WAIT) && gap_ok && spi_cs_n;

   sfe_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .tx_frame (cmd_frame),
      .miso     (spi_miso),
      .sclk     (spi_sclk),
      .cs_n     (spi_cs_n),
      .mosi     (spi_mosi),
      .fin      (fin),
      .rx_frame (rx_frame)
   );

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         second    <= 1'b0;
         cmd_frame <= '0;
         done      <= 1'b0;
         crc_err   <= 1'b0;
         dev_err   <= 1'b0;
         rstat     <= '0;
         rdata     <= '0;
      end else begin
         done    <= 1'b0;
         crc_err <= 1'b0;
         dev_err <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  cmd_frame <= {req_payload, tx_crc};
                  second    <= 1'b0;
                  state     <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (start) state <= ST_RUN;
            end
            ST_RUN: begin
               if (fin) begin
                  if (second) begin
                     state <= ST_CHECK;
                  end else begin
                     second <= 1'b1;
                     state  <= ST_WAIT;
                  end
               end
            end
            ST_CHECK: begin
               done  <= 1'b1;
               state <= ST_IDLE;
               if (!crc_ok) begin
                  crc_err <= 1'b1;
               end else begin
                  rstat   <= rx_frame[25:24];
                  rdata   <= ext_word;
                  dev_err <= (rx_frame[25:24] == RS_FAULT);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
   parameter int GAP_CLKS = 1000,
   parameter int OUT_W    = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             busy,
   input logic             done,
   input logic             crc_err,
   input logic             dev_err,
   input logic [OUT_W-1:0] rdata,
   input logic             spi_sclk,
   input logic             spi_cs_n,
   input logic             spi_mosi
);
   localparam int CW = $clog2(GAP_CLKS + 1);

   logic [CW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        hi_cnt <= '0;
      else if (!spi_cs_n)                hi_cnt <= '0;
      else if (hi_cnt != CW'(GAP_CLKS))  hi_cnt <= hi_cnt + CW'(1);
   end

   AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (hi_cnt >= CW'(GAP_CLKS))); // R4
   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk); // R1
   AST_MOSI_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sclk) |-> $stable(spi_mosi)); // R1
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy); // R8
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_err || dev_err) |-> done); // R6
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |-> $stable(rdata)); // R6
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(crc_err && dev_err)); // R7
endmodule

bind sens_frame_eng sfe_checker #(.GAP_CLKS(GAP_CLKS), .OUT_W(OUT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .crc_err   (crc_err),
   .dev_err   (dev_err),
   .rdata     (rdata),
   .spi_sclk  (spi_sclk),
   .spi_cs_n  (spi_cs_n),
   .spi_mosi  (spi_mosi)
);

// File: tb/sim_sens_frame_eng.sv
`timescale 1ns/1ps
module sim_sens_frame_eng;
   localparam int FREQ    = 2_000_000;
   localparam int GAPUS   = 10;
   localparam int DIV     = 2;
   localparam int GAP     = (FREQ / 1_000_000) * GAPUS;
   localparam int OW      = 32;

   typedef struct {
      logic [31:0] frame;
      logic [31:0] rdata;
      logic [1:0]  stat;
      logic        crc_e;
      logic        dev_e;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [4:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        busy, done, crc_err, dev_err;
   logic [1:0]  rstat;
   logic [31:0] rdata;
   logic        spi_sclk, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;

   int checks = 0;
   int failures = 0;
   int n_req = 0;
   int n_done = 0;
   bit finished = 1'b0;

   exp_t        exp_q[$];
   logic [31:0] resp_q[$];
   logic [31:0] cap_q[$];
   logic [31:0] last_rdata = '0;
   logic [1:0]  last_stat = '0;

   always #2 clk = ~clk;

   sens_frame_eng #(
      .CLK_FREQ_HZ(FREQ), .GAP_US(GAPUS), .CLK_DIV(DIV), .ADDR_W(5), .OUT_W(OW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .crc_err(crc_err), .dev_err(dev_err), .rstat(rstat), .rdata(rdata),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] tb_crc(input logic [23:0] p);
      logic [7:0] c;
      c = 8'hFF;
      for (int b = 0; b < 3; b++) begin
         c = c ^ p[23 - 8*b -: 8];
         for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h1D) : (c << 1);
      end
      return ~c;
   endfunction

   function automatic logic [31:0] tb_cmd(input bit wr, input logic [4:0] a, input logic [15:0] wd);
      logic [23:0] p;
      p = {wr, a, 2'b00, (wr ? wd : 16'h0000)};
      return {p, tb_crc(p)};
   endfunction

   function automatic logic [31:0] tb_resp(input logic [1:0] st, input logic [15:0] d, input bit bad);
      logic [23:0] p;
      p = {6'b000101, st, d};
      return {p, tb_crc(p) ^ (bad ? 8'h5A : 8'h00)};
   endfunction

   // sensor model: answers the second frame of each request with the queued reply
   logic [31:0] slv_sh = '0;
   logic [31:0] slv_cap = '0;
   int          slv_edges = 0;
   bit          slv_odd = 1'b0;
   bit          slv_seen = 1'b0;

   always @(negedge spi_cs_n) begin
      if (slv_odd && resp_q.size() > 0) slv_sh = resp_q.pop_front();
      else slv_sh = tb_resp(2'b11, 16'h7E57, 1'b0); // well-formed decoy
      slv_odd = !slv_odd;
      slv_seen = 1'b1;
      slv_edges = 0;
      spi_miso = slv_sh[31];
   end

   always @(posedge spi_sclk) if (!spi_cs_n) begin
      slv_cap = {slv_cap[30:0], spi_mosi};
      slv_edges++;
   end

   always @(negedge spi_sclk) if (!spi_cs_n) begin
      slv_sh = slv_sh << 1;
      spi_miso = slv_sh[31];
   end

   always @(posedge spi_cs_n) if (slv_seen && rst_n) begin
      check(slv_edges == 32, "R3 sclk edges per frame", slv_edges, 32);
      cap_q.push_back(slv_cap);
   end

   // chip-select gap monitor
   int  hi_cycles = 0;
   logic prev_cs = 1'b1;
   always @(negedge clk) begin
      if (!rst_n) begin
         hi_cycles = 0;
      end else if (spi_cs_n) begin
         hi_cycles++;
      end else begin
         if (prev_cs) check(hi_cycles >= GAP, "R4 cs gap", hi_cycles, GAP);
         hi_cycles = 0;
      end
      prev_cs = spi_cs_n;
   end

   // scoreboard monitor
   always @(negedge clk) if (rst_n && done) begin
      exp_t e;
      logic [31:0] f0, f1;
      n_done++;
      check(!busy, "R8 busy low with done", busy, 0);
      if (exp_q.size() == 0) begin
         check(1'b0, "R9 unexpected done", 1, 0);
      end else begin
         e = exp_q.pop_front();
         check(rdata == e.rdata, "R5 rdata", rdata, e.rdata);
         check(rstat == e.stat, "R7 rstat", rstat, e.stat);
         check(crc_err == e.crc_e, "R6 crc_err", crc_err, e.crc_e);
         check(dev_err == e.dev_e, "R7 dev_err", dev_err, e.dev_e);
         if (cap_q.size() >= 2) begin
            f0 = cap_q.pop_front();
            f1 = cap_q.pop_front();
            check(f0 == e.frame, "R1 R2 first frame", f0, e.frame);
            check(f1 == e.frame, "R3 second frame", f1, e.frame);
         end else begin
            check(1'b0, "R3 two frames", cap_q.size(), 2);
         end
      end
   end

   task automatic do_req(input bit wr, input logic [4:0] a, input logic [15:0] wd,
                         input logic [1:0] st, input logic [15:0] d, input bit bad, input bit poke);
      exp_t e;
      e.frame = tb_cmd(wr, a, wd);
      if (bad) begin
         e.rdata = last_rdata; e.stat = last_stat; e.crc_e = 1'b1; e.dev_e = 1'b0;
      end else begin
         e.rdata = {{16{d[15]}}, d}; e.stat = st; e.crc_e = 1'b0; e.dev_e = (st == 2'b11);
         last_rdata = e.rdata; last_stat = st;
      end
      @(negedge clk);
      while (busy) @(negedge clk);
      exp_q.push_back(e);
      resp_q.push_back(tb_resp(st, d, bad));
      n_req++;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      check(busy, "R8 busy after accept", busy, 1);
      if (poke) begin
         repeat (5) @(negedge clk);
         req_valid = 1'b1; req_write = !wr; req_addr = ~a; req_wdata = ~wd;
         repeat (3) @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R10 reset state
      check(spi_cs_n == 1'b1, "R10 cs_n", spi_cs_n, 1);
      check(spi_sclk == 1'b0, "R10 sclk", spi_sclk, 0);
      check(!busy && !done && !crc_err && !dev_err, "R10 flags",
            {busy, done, crc_err, dev_err}, 0);
      check(rdata == 0 && rstat == 0, "R10 rdata", rdata, 0);
      rst_n = 1'b1;

      // R2 known trailer
      check(tb_cmd(1'b0, 5'd6, 16'h0) == 32'h180000E5, "R2 trailer vector",
            tb_cmd(1'b0, 5'd6, 16'h0), 32'h180000E5);

      do_req(1'b0, 5'd6,  16'h0000, 2'b01, 16'h1234, 1'b0, 1'b0); // R2 R5
      do_req(1'b0, 5'd1,  16'h0000, 2'b00, 16'h8001, 1'b0, 1'b0); // R5 negative
      do_req(1'b1, 5'd13, 16'h0020, 2'b01, 16'h0000, 1'b0, 1'b0); // R1 write
      do_req(1'b0, 5'd16, 16'h0000, 2'b11, 16'h00C1, 1'b0, 1'b0); // R7 fault
      do_req(1'b0, 5'd2,  16'h0000, 2'b00, 16'h4321, 1'b1, 1'b0); // R6 bad crc
      do_req(1'b1, 5'd31, 16'hFFFF, 2'b10, 16'h7FFF, 1'b0, 1'b1); // R9 poke
      do_req(1'b0, 5'd3,  16'hAAAA, 2'b01, 16'hFFFF, 1'b0, 1'b0); // R4 back to back
      do_req(1'b0, 5'd5,  16'h0000, 2'b11, 16'h5555, 1'b1, 1'b0); // R6 bad crc, fault bits

      @(negedge clk);
      while (busy || exp_q.size() != 0) @(negedge clk);
      repeat (4 * GAP) @(negedge clk);
      check(n_done == n_req, "R9 done count", n_done, n_req);
      check(cap_q.size() == 0, "R3 extra frames", cap_q.size(), 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule